// File: doc/BRIEF.md
# Operate Instruction Execution Unit

This unit executes the three register-to-register operate instructions of a 16-bit load/store instruction set: two's complement add, bitwise AND and bitwise NOT. A 16-bit instruction word is presented with a one-cycle valid strobe. The unit decodes the word, reads its operands from an internal bank of eight 16-bit registers, writes the result back and updates a three-flag condition code (negative, zero, positive).

For add and AND, instruction bit 5 picks the second operand. When it is set, the operand is a sign-extended 5-bit constant. When it is clear, the operand comes from a second register. Encodings the unit does not handle raise a one-cycle error and change no state. Fetch, memory access and branching are handled elsewhere. A test port lets a bench load any register and read any register back.

Top module: `opu_top`

## Requirements
- R1: Opcode field instWord[15:12] selects the operation: 4'b0001 is add, 4'b0101 is AND and 4'b1001 is NOT. Any other opcode is reported as illegal.
- R2: The destination register number is instWord[11:9] and the first source register number is instWord[8:6].
- R3: For add and AND with instWord[5]=1, the second operand is instWord[4:0] read as a 5-bit two's complement number and sign-extended to 16 bits.
- R4: For add and AND with instWord[5]=0, the second operand is the register numbered by instWord[2:0].
- R5: Add is 16-bit two's complement addition, and the carry out of bit 15 is discarded.
- R6: Exactly one of flagN, flagZ and flagP is high at all times. After reset flagZ is high. After each write-back the flags show the written value: flagN when bit 15 is 1, flagZ when the value is zero, and flagP otherwise.
- R7: An AND with immediate 0 clears the destination register and sets flagZ.
- R8: A register-mode add or AND with instWord[4:3]≠00, a NOT with instWord[5:0]≠6'b111111, or an unknown opcode raises illegal for exactly one cycle. In that case no register and no flag changes.
- R9: The cycle after the valid strobe, done is high, and the result is written at the end of that cycle. An instruction in the next cycle reads the updated register. done and illegal are never high together and are both low when no instruction was presented.
- R10: When tstWrEn is high, tstWrData is written to register tstAddr at the clock edge. tstRdData always shows the current contents of register tstAddr. If an instruction writes the same register in the same cycle, the instruction's result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word is valid this cycle |
| instWord | input | 16 | Instruction word |
| done | output | 1 | Legal instruction writing back this cycle |
| illegal | output | 1 | Rejected encoding, one-cycle pulse |
| flagN | output | 1 | Negative condition flag |
| flagZ | output | 1 | Zero condition flag |
| flagP | output | 1 | Positive condition flag |
| tstWrEn | input | 1 | Test write enable |
| tstAddr | input | 3 | Test register number |
| tstWrData | input | 16 | Test write data |
| tstRdData | output | 16 | Contents of register tstAddr |

## Verification
Some properties are checked on every cycle: the flags are one-hot, every valid strobe resolves to exactly one of done or illegal on the next cycle, an error pulse lasts one cycle and leaves the flags alone, and an AND with immediate zero always leaves Z set. The result values need the bench's behavioural model and its scenarios. These include sign extension of negative constants, wrap-around on add overflow, register against immediate operand selection, and back-to-back use of a freshly written register. The scenarios also show that rejected encodings leave the register contents unchanged.

// File: rtl/opu_pkg.sv
package opu_pkg;
  localparam int DATA_W = 16;
  localparam int NUM_REGS = 8;
  localparam int REG_AW = $clog2(NUM_REGS);
  localparam int IMM_W = 5;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT} aluOp_e;

  typedef struct packed {
    logic              wrEn;
    logic              err;
    aluOp_e            op;
    logic              useImm;
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] srcA;
    logic [REG_AW-1:0] srcB;
    logic [DATA_W-1:0] imm;
  } ctlStrobe_t;
endpackage

// File: rtl/opu_ctrl.sv
module opu_ctrl
  import opu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [DATA_W-1:0] instWord,
  output ctlStrobe_t        ctl,
  output logic              done,
  output logic              illegal
);
  logic [DATA_W-1:0] instR;
  logic              validR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instR  <= '0;
      validR <= 1'b0;
    end else begin
      validR <= instValid;
      if (instValid) instR <= instWord;
    end
  end

  logic [OPC_W-1:0] opc;
  logic             legal;
  assign opc = instR[DATA_W-1 -: OPC_W];

  always_comb begin
    legal  = 1'b0;
    ctl.op = ALU_ADD;
    unique case (opc)
      OPC_ADD: begin legal = instR[5] | (instR[4:3] == 2'b00); ctl.op = ALU_ADD; end
      OPC_AND: begin legal = instR[5] | (instR[4:3] == 2'b00); ctl.op = ALU_AND; end
      OPC_NOT: begin legal = (instR[5:0] == 6'b111111);        ctl.op = ALU_NOT; end
      default: legal = 1'b0;
    endcase
    ctl.wrEn   = validR & legal;
    ctl.err    = validR & ~legal;
    ctl.useImm = instR[5];
    ctl.dst    = instR[11:9];
    ctl.srcA   = instR[8:6];
    ctl.srcB   = instR[2:0];
    ctl.imm    = {{(DATA_W-IMM_W){instR[IMM_W-1]}}, instR[IMM_W-1:0]};
  end

  assign done    = ctl.wrEn;
  assign illegal = ctl.err;

  // R9
  valid_resolves_chk: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> (done ^ illegal));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> !(done || illegal));
  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (illegal && !instValid) |=> !illegal);
endmodule

// File: rtl/opu_dpath.sv
module opu_dpath
  import opu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              tstWrEn,
  input  logic [REG_AW-1:0] tstAddr,
  input  logic [DATA_W-1:0] tstWrData,
  output logic [DATA_W-1:0] tstRdData,
  output logic [2:0]        cc
);
  logic [DATA_W-1:0] rf [NUM_REGS];
  logic [DATA_W-1:0] opA, opB, res;

  assign opA = rf[ctl.srcA];
  assign opB = ctl.useImm ? ctl.imm : rf[ctl.srcB];

  always_comb begin
    unique case (ctl.op)
      ALU_ADD: res = opA + opB;
      ALU_AND: res = opA & opB;
      default: res = ~opA;
    endcase
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN)
        rf[i] <= '0;
      else if (ctl.wrEn && ctl.dst == REG_AW'(i))
        rf[i] <= res;
      else if (tstWrEn && tstAddr == REG_AW'(i))
        rf[i] <= tstWrData;
    end
  end

  assign tstRdData = rf[tstAddr];

  always_ff @(posedge clk) begin
    if (!rstN)
      cc <= 3'b010;
    else if (ctl.wrEn)
      cc <= {res[DATA_W-1], res == '0, ~res[DATA_W-1] & (res != '0)};
  end

  // R6
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cc) == 1);
  // R8
  err_hold_cc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.err |=> $stable(cc));
  // R7
  and_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEn && ctl.op == ALU_AND && ctl.useImm && ctl.imm == '0) |=> cc == 3'b010);
endmodule

// File: rtl/opu_top.sv
module opu_top
  import opu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [15:0] instWord,
  output logic        done,
  output logic        illegal,
  output logic        flagN,
  output logic        flagZ,
  output logic        flagP,
  input  logic        tstWrEn,
  input  logic [2:0]  tstAddr,
  input  logic [15:0] tstWrData,
  output logic [15:0] tstRdData
);
  ctlStrobe_t ctl;
  logic [2:0] cc;

  opu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .ctl(ctl), .done(done), .illegal(illegal)
  );

  opu_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tstWrEn(tstWrEn), .tstAddr(tstAddr),
    .tstWrData(tstWrData), .tstRdData(tstRdData), .cc(cc)
  );

  assign {flagN, flagZ, flagP} = cc;
endmodule

// File: tb/opu_top_tb.sv
`timescale 1ns/1ps
module opu_top_tb;
  logic clk = 1'b0, rstN = 1'b0, instValid = 1'b0, tstWrEn = 1'b0;
  logic [15:0] instWord = '0, tstWrData = '0, tstRdData;
  logic [2:0] tstAddr = '0;
  logic done, illegal, flagN, flagZ, flagP;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  opu_top u_dut (.*);

  // behavioural reference model
  logic [15:0] mreg [8];
  logic [2:0]  mcc;
  bit          pendV;
  logic [15:0] pendW;

  function automatic bit legalEnc(logic [15:0] w);
    case (w[15:12])
      4'd1, 4'd5: return w[5] || w[4:3] == 2'b00;
      4'd9:       return w[5:0] == 6'h3f;
      default:    return 0;
    endcase
  endfunction

  function automatic logic [15:0] calc(logic [15:0] w);
    int a, b;
    a = mreg[w[8:6]];
    if (w[5]) b = (w[4:0] >= 16) ? int'(w[4:0]) - 32 : int'(w[4:0]);
    else      b = mreg[w[2:0]];
    case (w[15:12])
      4'd1:    return 16'(a + b);
      4'd5:    return 16'(a & b);
      default: return 16'(~a);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mreg[i]) mreg[i] = '0;
      mcc = 3'b010; pendV = 0; pendW = '0;
    end else begin
      logic [15:0] r;
      if (tstWrEn) mreg[tstAddr] = tstWrData;
      if (pendV && legalEnc(pendW)) begin
        r = calc(pendW);
        mreg[pendW[11:9]] = r;
        mcc = {r[15], r == 0, !r[15] && r != 0};
      end
      pendV = instValid; pendW = instWord;
    end
  end

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN && !finished) begin
    check(done == (pendV && legalEnc(pendW)), "R9 done", 16'(done), 16'(pendV && legalEnc(pendW)));
    check(illegal == (pendV && !legalEnc(pendW)), "R8 illegal", 16'(illegal), 16'(pendV && !legalEnc(pendW)));
    check({flagN, flagZ, flagP} == mcc, "R6 flags", 16'({flagN, flagZ, flagP}), 16'(mcc));
    check(tstRdData == mreg[tstAddr], "R2 regread", tstRdData, mreg[tstAddr]);
  end

  function automatic logic [15:0] enc(logic [3:0] op, int d, int s, logic [5:0] lo);
    return {op, 3'(d), 3'(s), lo};
  endfunction

  task automatic issue(logic [15:0] w);
    @(negedge clk); #1 instValid = 1; instWord = w;
    @(negedge clk); #1 instValid = 0;
    @(negedge clk);
  endtask

  task automatic chkReg(int a, logic [15:0] exp, string tag);
    @(negedge clk); #1 tstAddr = 3'(a); #1;
    check(tstRdData === exp, tag, tstRdData, exp);
  endtask

  task automatic chkCc(logic [2:0] exp, string tag);
    #1 check({flagN, flagZ, flagP} === exp, tag, 16'({flagN, flagZ, flagP}), 16'(exp));
  endtask

  task automatic finishSim();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishSim();
  end

  initial begin
    logic [15:0] pre [8] = '{16'h0005, 16'h7fff, 16'h0001, 16'h8000,
                             16'h0ff0, 16'h1234, 16'hffff, 16'h0f0f};
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    chkReg(3, 16'h0000, "R6 reset reg");
    chkCc(3'b010, "R6 reset flags");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1 tstWrEn = 1; tstAddr = 3'(i); tstWrData = pre[i];
    end
    @(negedge clk); #1 tstWrEn = 0;
    chkReg(5, 16'h1234, "R10 preload");
    issue(enc(4'b0001, 0, 1, 6'b000010));   // add r0=r1+r2
    chkReg(0, 16'h8000, "R5 add wrap / R4 reg operand");
    chkCc(3'b100, "R6 negative");
    issue(enc(4'b0001, 1, 6, 6'b100001));   // add r1=r6+1
    chkReg(1, 16'h0000, "R3 imm +1");
    chkCc(3'b010, "R6 zero");
    issue(enc(4'b0001, 2, 5, 6'b110000));   // add r2=r5-16
    chkReg(2, 16'h1224, "R3 sign-extended -16");
    chkCc(3'b001, "R6 positive");
    issue(enc(4'b0101, 3, 4, 6'b000111));   // and r3=r4&r7
    chkReg(3, 16'h0f00, "R4 and register");
    issue(enc(4'b0101, 4, 5, 6'b100000));   // and r4=r5&0
    chkReg(4, 16'h0000, "R7 and zero");
    chkCc(3'b010, "R7 zero flag");
    issue(enc(4'b0101, 5, 6, 6'b111111));   // and r5=r6&-1
    chkReg(5, 16'hffff, "R3 and imm -1");
    issue(enc(4'b1001, 6, 7, 6'b111111));   // not r6=~r7
    chkReg(6, 16'hf0f0, "R1 not");
    chkCc(3'b100, "R1 not flags");
    issue(enc(4'b1001, 0, 1, 6'b111110));   // bad not
    chkReg(0, 16'h8000, "R8 bad not keeps reg");
    chkCc(3'b100, "R8 bad not keeps flags");
    issue(enc(4'b0001, 1, 2, 6'b001010));   // add with bits 4:3=01
    chkReg(1, 16'h0000, "R8 bad add keeps reg");
    issue(enc(4'b0010, 2, 3, 6'b000000));   // unknown opcode
    chkReg(2, 16'h1224, "R1 unknown opcode keeps reg");
    // back-to-back increments of r7
    @(negedge clk); #1 instValid = 1; instWord = enc(4'b0001, 7, 7, 6'b100001);
    @(negedge clk); #1 instWord = enc(4'b0001, 7, 7, 6'b100001);
    @(negedge clk); #1 instValid = 0;
    @(negedge clk);
    chkReg(7, 16'h0f11, "R9 back-to-back");
    // instruction write and test write to the same register
    @(negedge clk); #1 instValid = 1; instWord = enc(4'b0101, 3, 3, 6'b100000);
    @(negedge clk); #1 instValid = 0; tstWrEn = 1; tstAddr = 3; tstWrData = 16'habcd;
    @(negedge clk); #1 tstWrEn = 0;
    chkReg(3, 16'h0000, "R10 instruction wins");
    repeat (3) @(negedge clk);
    finishSim();
  end
endmodule